// File: doc/BRIEF.md
# Two-Read Two-Write Integer Register File

This block holds the architectural integer registers of a small 64-bit processor core. It has sixteen index codes, fifteen stored 64-bit registers and one reserved code. Two read ports return register contents combinationally from the stored state. Two write ports update registers at the rising clock edge. The read ports usually serve the two source operands of an instruction. The write ports usually carry an execution result and a loaded value.

The all-ones index (15) is a placeholder for "no register". A read port given code 15 returns zero, and a write port given code 15 changes nothing. No storage exists for that code. Code 4 holds the stack pointer by convention, but the block treats it like any other register. When both write ports name the same real register in one cycle, the value on the M port is stored. Reads never see a value that is being written in the same cycle. The new value appears only after the clock edge.

Top module: `rf_dual_rw`

## Requirements
- R1: `rd_a_data` shows, in the same cycle, the stored value of the register named by `rd_a_idx` (codes 0 to 14).
- R2: `rd_b_data` shows, in the same cycle, the stored value of the register named by `rd_b_idx` (codes 0 to 14). Both read ports work independently and may name the same register.
- R3: A read index of 15 (4'b1111) gives an all-zero 64-bit result on that port.
- R4: When `wr_e_idx` is 0 to 14 and `wr_m_idx` names a different code, the register named by `wr_e_idx` takes `wr_e_data` at the rising edge.
- R5: When `wr_m_idx` is 0 to 14, the register it names takes `wr_m_data` at the rising edge.
- R6: A write index of 15 on either port changes no register.
- R7: When `wr_e_idx` and `wr_m_idx` name the same real register in one cycle, the register stores `wr_m_data`.
- R8: A read of a register that is being written in the same cycle returns the value held before the edge. The new value is visible from the cycle after the edge.
- R9: While `rst` is high at a rising edge (synchronous, active high), every register becomes zero.
- R10: A register named by neither write port keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| rd_a_idx | input | 4 | Source index for read port A (15 = none) |
| rd_a_data | output | 64 | Value read on port A |
| rd_b_idx | input | 4 | Source index for read port B (15 = none) |
| rd_b_data | output | 64 | Value read on port B |
| wr_e_idx | input | 4 | Destination index for write port E (15 = none) |
| wr_e_data | input | 64 | Data for write port E |
| wr_m_idx | input | 4 | Destination index for write port M (15 = none) |
| wr_m_data | input | 64 | Data for write port M; takes priority over E |

## Verification
The assertions check these rules on every clock cycle:
- Each register slot takes the M data when M names it.
- Otherwise, the slot takes the E data when E names it.
- Otherwise, the slot holds its value.
- A reset clears the slot.
- Each write port enables at most one slot.
- A reserved read index gives zero.

Some behaviour can only be shown by the bench scenarios, which compare the read ports against a model:
- Reads return the old value during a write to the same register.
- The reserved write code leaves all fifteen registers unchanged.
- Both read ports agree when they name the same register.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_IDX_W  = 4;
    localparam int RF_DATA_W = 64;
    localparam int RF_CODES  = 1 << RF_IDX_W;
    localparam int RF_SLOTS  = RF_CODES - 1;
    localparam logic [RF_IDX_W-1:0] RF_NONE = {RF_IDX_W{1'b1}};

    typedef logic [RF_IDX_W-1:0]  rf_idx_t;
    typedef logic [RF_DATA_W-1:0] rf_word_t;

    typedef struct packed {
        rf_idx_t  idx;
        rf_word_t data;
    } rf_wr_t;

    function automatic logic rf_is_none(input rf_idx_t idx);
        return idx == RF_NONE;
    endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  rf_idx_t             e_idx,
    input  rf_idx_t             m_idx,
    output logic [RF_SLOTS-1:0] hit_e,
    output logic [RF_SLOTS-1:0] hit_m
);

    for (genvar s = 0; s < RF_SLOTS; s++) begin : g_dec
        assign hit_e[s] = (e_idx == RF_IDX_W'(s));
        assign hit_m[s] = (m_idx == RF_IDX_W'(s));
    end

    // R7 needs a single winner per port; R6 needs the reserved code to enable nothing
    p_single_e_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_e));
    p_single_m_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_m));
    p_none_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (rf_is_none(e_idx) && rf_is_none(m_idx)) |-> ($countones({hit_e, hit_m}) == 0));

endmodule

// File: rtl/rf_slot.sv
module rf_slot
    import rf_pkg::*;
#(
    parameter int SLOT_ID = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hit_e,
    input  logic     hit_m,
    input  rf_wr_t   req_e,
    input  rf_wr_t   req_m,
    output rf_word_t q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (hit_m) q <= req_m.data;
        else if (hit_e) q <= req_e.data;
    end

    localparam rf_idx_t ME = RF_IDX_W'(SLOT_ID);

    p_m_write_r5: assert property (@(posedge clk) disable iff (rst)
        (req_m.idx == ME) |=> (q == $past(req_m.data)));
    p_e_write_r4: assert property (@(posedge clk) disable iff (rst)
        (req_e.idx == ME && req_m.idx != ME) |=> (q == $past(req_e.data)));
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req_e.idx != ME && req_m.idx != ME) |=> $stable(q));
    p_reset_clear_r9: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
    import rf_pkg::*;
(
    input  rf_idx_t  idx,
    input  rf_word_t slots [RF_SLOTS],
    output rf_word_t data
);

    always_comb begin
        data = '0;
        for (int i = 0; i < RF_SLOTS; i++) begin
            if (idx == RF_IDX_W'(i)) data = slots[i];
        end
    end

endmodule

// File: rtl/rf_dual_rw.sv
module rf_dual_rw
    import rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_a_idx,
    output logic [63:0] rd_a_data,
    input  logic [3:0]  rd_b_idx,
    output logic [63:0] rd_b_data,
    input  logic [3:0]  wr_e_idx,
    input  logic [63:0] wr_e_data,
    input  logic [3:0]  wr_m_idx,
    input  logic [63:0] wr_m_data
);

    rf_wr_t              req_e, req_m;
    logic [RF_SLOTS-1:0] hit_e, hit_m;
    rf_word_t            slot_q [RF_SLOTS];

    assign req_e = '{idx: wr_e_idx, data: wr_e_data};
    assign req_m = '{idx: wr_m_idx, data: wr_m_data};

    rf_wr_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .e_idx (req_e.idx),
        .m_idx (req_m.idx),
        .hit_e (hit_e),
        .hit_m (hit_m)
    );

    for (genvar s = 0; s < RF_SLOTS; s++) begin : g_slot
        rf_slot #(.SLOT_ID(s)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .hit_e (hit_e[s]),
            .hit_m (hit_m[s]),
            .req_e (req_e),
            .req_m (req_m),
            .q     (slot_q[s])
        );
    end

    rf_rd_port u_rd_a (.idx(rd_a_idx), .slots(slot_q), .data(rd_a_data));
    rf_rd_port u_rd_b (.idx(rd_b_idx), .slots(slot_q), .data(rd_b_data));

    p_none_read_a_r3: assert property (@(posedge clk) disable iff (rst)
        rf_is_none(rd_a_idx) |-> (rd_a_data == '0));
    p_none_read_b_r3: assert property (@(posedge clk) disable iff (rst)
        rf_is_none(rd_b_idx) |-> (rd_b_data == '0));
    p_same_src_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

endmodule

// File: tb/rf_dual_rw_tb.sv
module rf_dual_rw_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_e_idx = 4'hF, wr_m_idx = 4'hF;
    logic [63:0] rd_a_data, rd_b_data, wr_e_data = '0, wr_m_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] mdl [15];

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_dual_rw dut_i (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_e_idx(wr_e_idx), .wr_e_data(wr_e_data),
        .wr_m_idx(wr_m_idx), .wr_m_data(wr_m_data)
    );

    function automatic logic [63:0] exp_rd(input logic [3:0] idx);
        return (idx == 4'hF) ? 64'd0 : mdl[idx];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // model of the edge: M wins, reserved code writes nothing
    task automatic step();
        logic [3:0] e, m; logic [63:0] de, dm; logic r;
        e = wr_e_idx; m = wr_m_idx; de = wr_e_data; dm = wr_m_data; r = rst;
        @(posedge clk);
        if (r) for (int i = 0; i < 15; i++) mdl[i] = '0;
        else begin
            if (e != 4'hF) mdl[e] = de;
            if (m != 4'hF) mdl[m] = dm;
        end
        @(negedge clk);
    endtask

    task automatic set_wr(input logic [3:0] e, input logic [63:0] de,
                          input logic [3:0] m, input logic [63:0] dm);
        wr_e_idx = e; wr_e_data = de; wr_m_idx = m; wr_m_data = dm;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
            #1;
            check(req, rd_a_data, exp_rd(rd_a_idx));
            check(req, rd_b_data, exp_rd(rd_b_idx));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        for (int i = 0; i < 15; i++) mdl[i] = 64'hDEAD_BEEF_0000_0000 | 64'(i);
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        sweep("R9 reset clears");

        // directed: E and M to different registers
        set_wr(4'd3, 64'h1111_2222_3333_4444, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD);
        step();
        set_wr(4'hF, '0, 4'hF, '0);
        rd_a_idx = 4'd3; rd_b_idx = 4'd4; #1;
        check("R4 E write", rd_a_data, 64'h1111_2222_3333_4444);
        check("R5 M write", rd_b_data, 64'hAAAA_BBBB_CCCC_DDDD);

        // R8: read while writing returns old value
        set_wr(4'd3, 64'h5555, 4'hF, '0);
        rd_a_idx = 4'd3; #1;
        check("R8 old value before edge", rd_a_data, 64'h1111_2222_3333_4444);
        step();
        check("R8 new value after edge", rd_a_data, 64'h5555);

        // R7: collision, M wins
        set_wr(4'd7, 64'hEEEE, 4'd7, 64'h7777);
        step();
        set_wr(4'hF, '0, 4'hF, '0);
        rd_a_idx = 4'd7; #1;
        check("R7 M wins collision", rd_a_data, 64'h7777);

        // R6: reserved write code, data all ones
        set_wr(4'hF, '1, 4'hF, '1);
        step();
        sweep("R6 reserved write ignored");

        // R3 / R2: reserved read and shared source
        rd_a_idx = 4'hF; rd_b_idx = 4'hF; #1;
        check("R3 reserved read A", rd_a_data, 64'd0);
        check("R3 reserved read B", rd_b_data, 64'd0);
        rd_a_idx = 4'd4; rd_b_idx = 4'd4; #1;
        check("R2 same source", rd_b_data, rd_a_data);

        // random traffic: R1, R2, R8, R10
        for (int c = 0; c < 2000; c++) begin
            set_wr(4'($urandom_range(0, 15)), {$urandom, $urandom},
                   ($urandom_range(0, 3) == 0) ? wr_e_idx : 4'($urandom_range(0, 15)),
                   {$urandom, $urandom});
            rd_a_idx = 4'($urandom_range(0, 15));
            rd_b_idx = 4'($urandom_range(0, 15));
            #1;
            check("R1 random read A", rd_a_data, exp_rd(rd_a_idx));
            check("R2 random read B", rd_b_data, exp_rd(rd_b_idx));
            step();
        end
        set_wr(4'hF, '0, 4'hF, '0);
        sweep("R10 untouched registers hold");

        // reset mid-run with writes pending
        rst = 1'b1;
        set_wr(4'd1, 64'h99, 4'd2, 64'h98);
        step();
        rst = 1'b0;
        set_wr(4'hF, '0, 4'hF, '0);
        sweep("R9 reset mid-run");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule